// File: doc/BRIEF.md
# Supervisor Kick Toggler

This block keeps an external watchdog supervisor satisfied by toggling an output pin at a fixed, safe rate. The supervisor's hardware margin is given in clock ticks. The pin flips once every half of that margin, which leaves a full half-margin of slack before the supervisor would act.

The host controls the block with three single-cycle strobes. Start arms the block and begins toggling. Stop disarms it. Ping tells the block the host is still alive. While armed, the block counts the ticks since the last start or ping. If that count passes the user timeout, the block stops toggling and raises an expired flag, and the supervisor then resets the system.

An always-running configuration bit lets toggling begin on its own straight after reset. In that mode a stop only disarms the block, and the pin keeps toggling. An active-low bit selects the pin level that toggling starts from. When the block is idle, it tri-states the pin by dropping the output enable.

Top module: `kick_toggler`

## Requirements
- R1: During and after reset, with always-running clear and no start, pin_o is 0, pin_oe_o is 0 and expired_o is 0.
- R2: A start strobe (without stop) sets pin_o to active_low_i, sets pin_oe_o to 1 and clears expired_o, all visible after the clock edge that samples it.
- R3: While toggling, pin_o inverts every H cycles, where H = margin_i >> 1, or H = 1 if that shift is 0. The first inversion comes H cycles after the start edge.
- R4: With always_run_i set, the first clock edge after reset drives pin_o to active_low_i with pin_oe_o = 1, and toggling then follows R3 without any start.
- R5: With always_run_i clear, a stop strobe drives pin_oe_o to 0 on the next edge, and pin_o stops changing.
- R6: With always_run_i set, a stop strobe only disarms the block: pin_oe_o stays 1, toggling continues, and no expiry follows.
- R7: While armed, the block stops toggling at the edge T+1 cycles after the last start or ping edge, where T = timeout_i. At that edge expired_o goes to 1, pin_o then holds its level and pin_oe_o stays 1.
- R8: A ping while toggling restarts the elapsed count, so pings spaced at most T cycles apart prevent expiry.
- R9: A ping while the block is not toggling (idle or expired) has no effect on pin_o, pin_oe_o or expired_o.
- R10: When start and stop arrive in the same cycle, stop wins.
- R11: While disarmed, the timeout is never checked, and expired_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm and start toggling (strobe) |
| stop_i | input | 1 | Disarm (strobe) |
| ping_i | input | 1 | Host keep-alive (strobe) |
| always_run_i | input | 1 | Toggle from reset without a client |
| active_low_i | input | 1 | Pin level driven on start |
| margin_i | input | TW | Supervisor hardware margin in ticks |
| timeout_i | input | TW | User timeout in ticks |
| pin_o | output | 1 | Kick pin value |
| pin_oe_o | output | 1 | Kick pin output enable |
| expired_o | output | 1 | Toggling ceased on user timeout |

## Verification
The toggle period is swept over margins 1, 2, 3, 4, 5, 8 and 11 with both active-low settings. These margins cover odd and even values as well as the clamp to one cycle, and they show whether the halving rounds down and whether the start level is taken from the configuration. The timeout is swept from 0 to 6 to show that expiry comes exactly one cycle past T, with no off-by-one in either direction. A single late ping and a steady stream of pings show that the elapsed count restarts on each ping. The always-running runs compare armed and disarmed operation, showing that the stop strobe does different things in the two modes and that the timeout applies only while armed.

// File: rtl/kick_toggler.sv
module kick_toggler #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ping_i,
  input  logic          always_run_i,
  input  logic          active_low_i,
  input  logic [TW-1:0] margin_i,
  input  logic [TW-1:0] timeout_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          expired_o
);

  logic          booted, run, armed;
  logic [TW-1:0] half_cnt, elapsed;

  wire [TW-1:0] half_raw   = margin_i >> 1;
  wire [TW-1:0] half       = (half_raw == '0) ? TW'(1) : half_raw;
  wire          boot_start = !booted && always_run_i;
  wire          timed_out  = armed && (elapsed >= timeout_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      booted    <= 1'b0;
      run       <= 1'b0;
      armed     <= 1'b0;
      half_cnt  <= '0;
      elapsed   <= '0;
      pin_o     <= 1'b0;
      pin_oe_o  <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      booted <= 1'b1;
      if (stop_i) begin
        armed <= 1'b0;
        if (!always_run_i) begin
          run      <= 1'b0;
          pin_oe_o <= 1'b0;
        end
      end else if (start_i || boot_start) begin
        if (start_i) begin
          armed     <= 1'b1;
          expired_o <= 1'b0;
        end
        run      <= 1'b1;
        pin_oe_o <= 1'b1;
        pin_o    <= active_low_i;
        half_cnt <= '0;
        elapsed  <= '0;
      end else if (run) begin
        if (timed_out) begin
          run       <= 1'b0;
          expired_o <= 1'b1;
        end else begin
          if (ping_i)        elapsed <= '0;
          else if (~&elapsed) elapsed <= elapsed + 1'b1;
          if (half_cnt >= half - 1'b1) begin
            half_cnt <= '0;
            pin_o    <= ~pin_o;
          end else begin
            half_cnt <= half_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

module kick_toggler_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic always_run_i,
  input logic active_low_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic expired_o,
  input logic armed,
  input logic booted
);

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !stop_i |=> pin_oe_o && !expired_o && (pin_o == $past(active_low_i))); // R2

  AST_STOP_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !always_run_i |=> !pin_oe_o); // R5

  AST_STOP_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && always_run_i && pin_oe_o |=> pin_oe_o); // R6

  AST_HELD_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !start_i |=> $stable(pin_o)); // R7

  AST_IDLE_PIN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o && !start_i && booted |=> $stable(pin_o) && !pin_oe_o); // R9

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && stop_i && !always_run_i |=> !pin_oe_o); // R10

  AST_EXPIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> $past(armed)); // R11

endmodule

bind kick_toggler kick_toggler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .always_run_i(always_run_i), .active_low_i(active_low_i),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o), .expired_o(expired_o),
  .armed(armed), .booted(booted)
);

// File: tb/tb_kick_toggler.sv
module tb_kick_toggler;
  localparam int TW = 16;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, ping_i = 0, always_run_i = 0, active_low_i = 0;
  logic [TW-1:0] margin_i = 4, timeout_i = 1000;
  logic pin_o, pin_oe_o, expired_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kick_toggler #(.TW(TW)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit st, input bit sp, input bit pg);
    start_i = st; stop_i = sp; ping_i = pg;
    @(negedge clk);
    start_i = 0; stop_i = 0; ping_i = 0;
  endtask

  task automatic next_toggle(output int k);
    logic p;
    p = pin_o; k = 0;
    do begin @(negedge clk); k++; end while (pin_o == p && k < 200);
  endtask

  task automatic wait_expired(output int k);
    k = 0;
    while (!expired_o && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic count_toggles(input int n, output int t);
    logic p;
    t = 0;
    for (int i = 0; i < n; i++) begin
      p = pin_o; @(negedge clk);
      if (pin_o != p) t++;
    end
  endtask

  task automatic do_reset(input bit ar, input bit al);
    always_run_i = ar; active_low_i = al;
    rst_n = 0; cyc(3); rst_n = 1;
  endtask

  initial begin
    int k, t, h, ms[7];
    logic p;
    ms = '{1, 2, 3, 4, 5, 8, 11};
    @(negedge clk); @(negedge clk);
    check(!pin_oe_o && !expired_o && !pin_o, "R1 reset state", {pin_o, pin_oe_o, expired_o}, 0);
    rst_n = 1; cyc(5);
    check(!pin_oe_o && !pin_o, "R1 idle without start", pin_oe_o, 0);
    pulse(0, 0, 1); cyc(2);
    check(!pin_oe_o && !pin_o && !expired_o, "R9 ping while idle", {pin_o, pin_oe_o, expired_o}, 0);

    for (int al = 0; al < 2; al++)
      foreach (ms[i]) begin
        margin_i = ms[i]; timeout_i = 1000; active_low_i = al[0];
        h = (ms[i] >> 1) == 0 ? 1 : ms[i] >> 1;
        pulse(1, 0, 0);
        check(pin_oe_o && pin_o == al[0], "R2 start level", pin_o, al);
        next_toggle(k); check(k == h, "R3 first toggle", k, h);
        next_toggle(k); check(k == h, "R3 second toggle", k, h);
        pulse(0, 1, 0);
        check(!pin_oe_o, "R5 stop tristates", pin_oe_o, 0);
        p = pin_o; cyc(h * 3 + 2);
        check(pin_o == p && !pin_oe_o, "R5 toggling halted", pin_o, p);
      end

    margin_i = 4; active_low_i = 0;
    for (int T = 0; T <= 6; T++) begin
      timeout_i = T;
      pulse(1, 0, 0);
      wait_expired(k);
      check(k == T + 1, "R7 expiry delay", k, T + 1);
      check(pin_oe_o, "R7 drive kept", pin_oe_o, 1);
      p = pin_o; cyc(5);
      check(pin_o == p && expired_o, "R7 pin held", pin_o, p);
      pulse(0, 0, 1); cyc(3);
      check(pin_o == p && expired_o && pin_oe_o, "R9 ping after expiry", expired_o, 1);
      pulse(1, 0, 0);
      check(!expired_o, "R2 start clears expired", expired_o, 0);
      pulse(0, 1, 0);
    end

    timeout_i = 5;
    pulse(1, 0, 0); cyc(3);
    pulse(0, 0, 1);
    wait_expired(k);
    check(k == 6, "R8 expiry after late ping", k, 6);
    pulse(1, 0, 0);
    for (int i = 0; i < 12; i++) begin pulse(0, 0, 1); cyc(2); end
    check(!expired_o && pin_oe_o, "R8 steady pings", expired_o, 0);
    pulse(0, 1, 0);

    pulse(1, 1, 0);
    check(!pin_oe_o, "R10 stop wins from idle", pin_oe_o, 1);
    pulse(1, 0, 0);
    pulse(1, 1, 0);
    check(!pin_oe_o, "R10 stop wins while running", pin_oe_o, 1);

    margin_i = 6; timeout_i = 4;
    do_reset(1, 1);
    @(negedge clk);
    check(pin_oe_o && pin_o, "R4 boot level", {pin_oe_o, pin_o}, 3);
    next_toggle(k); check(k == 3, "R4 boot toggle period", k, 3);
    count_toggles(30, t);
    check(t == 10 && !expired_o, "R11 disarmed never expires", t, 10);
    pulse(1, 0, 0); cyc(1);
    pulse(0, 1, 0);
    check(pin_oe_o, "R6 stop keeps drive", pin_oe_o, 1);
    count_toggles(30, t);
    check(t == 10 && !expired_o, "R6 toggling continues", t, 10);
    pulse(1, 0, 0);
    wait_expired(k);
    check(k == 5, "R7 expiry in always-run", k, 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule